// File: doc/BRIEF.md
# PLL Loop-Filter Bandwidth Mode Controller

This block decides whether a PLL loop filter runs wide-band (acquisition, large frequency corrections) or narrow-band (tracking, small low-jitter corrections), and it reports when the VCO output is stable enough to be used as the chip's base clock. It takes reference and feedback clock edge pulses, each one system clock cycle wide and already synchronized into the system clock domain. It counts feedback pulses over a window of `WIN_LEN` reference pulses and turns the gap between the two counts into an absolute frequency error.

In automatic mode a lock sequencer moves the filter between the two modes from these window results. In manual mode the mode follows a bit written by software. The lock detector runs in both modes. Its LOCK state drives the safe-to-select output to the base clock selector, raises a sticky interrupt flag whenever it changes, and is compared with the selector's current choice so that a lost lock while the VCO is in use is reported. Reference and feedback pulses are plain sampled strobes with no back-pressure. The register port is a plain write strobe with a continuously visible readback word, so no valid/ready handshake applies.

Top module: `pll_bw_ctrl`

## Requirements
- R1: After reset the filter is in acquisition (`track_mode` = 0), LOCK = 0, the flag = 0, and AUTO, IE and the manual ACQ bit are all 0.
- R2: A window closes on the `WIN_LEN`-th reference pulse since the last close. A feedback pulse in that same cycle belongs to the closing window. The window error is |feedback count − `WIN_LEN`|.
- R3: With AUTO = 1, a window error of at most 8 puts the filter in tracking (`track_mode` = 1), and an error above 8 puts it back in acquisition.
- R4: In either mode, LOCK sets at the end of the second consecutive window with error at most 2. A window with error from 3 to 8 leaves LOCK unchanged and restarts the run of good windows.
- R5: In either mode, a window error above 8 clears LOCK.
- R6: With AUTO = 0, `track_mode` equals the written ACQ bit (write bit 0, 1 = tracking), and window results do not change it.
- R7: `vco_safe` equals LOCK.
- R8: The flag sets on every LOCK transition and stays set until a write with bit 3 = 1 clears it. A transition in the same cycle as the clear wins.
- R9: `pll_irq` is high exactly when the flag is set and IE (write bit 2) is 1.
- R10: `lost_lock` is high one cycle after a cycle in which `vco_selected` = 1 and LOCK = 0, and low otherwise.
- R11: A write loads ACQ from bit 0, AUTO from bit 1 and IE from bit 2. Readback holds the effective mode (1 = tracking) in bit 0, AUTO in bit 1, IE in bit 2, the flag in bit 3 and LOCK in bit 4.
- R12: While `pll_en` = 0, LOCK is cleared, the automatic mode returns to acquisition and the window restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_en | input | 1 | PLL enable; low holds the detector in its start state |
| ref_pulse | input | 1 | One-cycle reference edge strobe |
| fb_pulse | input | 1 | One-cycle feedback edge strobe |
| vco_selected | input | 1 | High while the base clock selector uses the VCO |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write word: ACQ, AUTO, IE, flag-clear |
| reg_rdata | output | 5 | Readback: mode, AUTO, IE, flag, LOCK |
| track_mode | output | 1 | Filter mode: 1 tracking, 0 acquisition |
| vco_safe | output | 1 | VCO may be selected as base clock |
| pll_irq | output | 1 | Interrupt request |
| lost_lock | output | 1 | Lock lost while the VCO is selected |

## Verification
The assertions assume that `ref_pulse` and `fb_pulse` are already single-cycle strobes in the system clock domain, and that `pll_en` and register writes change only between clock edges. The bench drives every input on the falling edge. It emits at most one reference pulse every two cycles, and it places extra feedback pulses in the gaps, so every window carries a chosen exact count. Register writes are issued only while no window is closing, except where a test deliberately checks ordering.

// File: rtl/pll_bw_pkg.sv
`timescale 1ns/1ps
package pll_bw_pkg;
  // write word, bit 0 upward: manual mode, auto enable, irq enable, flag clear
  typedef struct packed {
    logic flag_clr;
    logic irq_en;
    logic auto_en;
    logic acq;
  } ctl_wr_t;

  // readback bit positions
  localparam int RD_MODE = 0;
  localparam int RD_AUTO = 1;
  localparam int RD_IE   = 2;
  localparam int RD_FLAG = 3;
  localparam int RD_LOCK = 4;
  localparam int RD_W    = 5;
endpackage

// File: rtl/pll_win_meter.sv
`timescale 1ns/1ps
module pll_win_meter #(
  parameter int unsigned WIN_LEN = 256,
  parameter int unsigned ERR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             done,
  output logic [ERR_W-1:0] err
);
  localparam int unsigned RW      = $clog2(WIN_LEN);
  localparam int unsigned FW      = $clog2(2*WIN_LEN+1) + 1;
  localparam int unsigned ERR_MAX = (1 << ERR_W) - 1;
  localparam logic [RW-1:0] REF_LAST = RW'(WIN_LEN - 1);
  localparam logic [FW-1:0] WIN_F    = FW'(WIN_LEN);

  logic [RW-1:0]    ref_cnt;
  logic [FW-1:0]    fb_cnt, fb_next, diff;
  logic             last;
  logic [ERR_W-1:0] err_next;

  always_comb begin
    fb_next = (fb_cnt == '1) ? fb_cnt : fb_cnt + FW'(fb_pulse);
    last    = ref_pulse && (ref_cnt == REF_LAST);
    diff    = (fb_next >= WIN_F) ? (fb_next - WIN_F) : (WIN_F - fb_next);
    if (32'(diff) > ERR_MAX) err_next = ERR_W'(ERR_MAX);
    else                     err_next = ERR_W'(diff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
      done    <= 1'b0;
      err     <= '0;
    end else if (last) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
      done    <= 1'b1;
      err     <= err_next;
    end else begin
      ref_cnt <= ref_cnt + RW'(ref_pulse);
      fb_cnt  <= fb_next;
      done    <= 1'b0;
    end
  end

  AST_DONE_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ref_pulse));   // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);              // R2
  AST_EN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done);               // R12
endmodule

// File: rtl/pll_lock_seq.sv
`timescale 1ns/1ps
module pll_lock_seq #(
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned TRACK_TOL = 8,
  parameter int unsigned LOCK_TOL  = 2,
  parameter int unsigned LOCK_RUNS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             done,
  input  logic [ERR_W-1:0] err,
  input  logic             auto_en,
  output logic             lock,
  output logic             auto_track
);
  localparam int unsigned GW = $clog2(LOCK_RUNS + 1);
  localparam logic [GW-1:0] GOOD_MAX  = GW'(LOCK_RUNS);
  localparam logic [GW-1:0] GOOD_NEED = GW'(LOCK_RUNS - 1);

  logic [GW-1:0] good_cnt;
  logic          big_err, fine_err;

  always_comb begin
    big_err  = 32'(err) > TRACK_TOL;
    fine_err = 32'(err) <= LOCK_TOL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      lock       <= 1'b0;
      auto_track <= 1'b0;
      good_cnt   <= '0;
    end else if (done) begin
      if (big_err) begin
        lock     <= 1'b0;
        good_cnt <= '0;
        if (auto_en) auto_track <= 1'b0;
      end else begin
        if (auto_en) auto_track <= 1'b1;
        if (fine_err) begin
          if (good_cnt >= GOOD_NEED) lock <= 1'b1;
          if (good_cnt != GOOD_MAX) good_cnt <= good_cnt + 1'b1;
        end else begin
          good_cnt <= '0;
        end
      end
    end
  end

  AST_LOCK_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(done));                          // R4
  AST_BIG_ERR_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done && big_err) |=> !lock);                    // R5
  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!lock && !auto_track));                       // R12
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !auto_en) |=> $stable(auto_track));             // R6
endmodule

// File: rtl/pll_bw_regs.sv
`timescale 1ns/1ps
module pll_bw_regs
  import pll_bw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  ctl_wr_t wr_word,
  input  logic    lock,
  output logic    sw_acq,
  output logic    auto_en,
  output logic    irq_en,
  output logic    flag,
  output logic    irq
);
  logic lock_prev, lock_chg, clr_req;

  always_comb begin
    lock_chg = lock ^ lock_prev;
    clr_req  = wr_en && wr_word.flag_clr;
    irq      = flag && irq_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_acq    <= 1'b0;
      auto_en   <= 1'b0;
      irq_en    <= 1'b0;
      flag      <= 1'b0;
      lock_prev <= 1'b0;
    end else begin
      lock_prev <= lock;
      if (wr_en) begin
        sw_acq  <= wr_word.acq;
        auto_en <= wr_word.auto_en;
        irq_en  <= wr_word.irq_en;
      end
      flag <= (flag && !clr_req) || lock_chg;
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != lock_prev) |=> flag);               // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);                // R8
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && (lock == lock_prev)) |=> !flag); // R8
endmodule

// File: rtl/pll_bw_ctrl.sv
`timescale 1ns/1ps
module pll_bw_ctrl
  import pll_bw_pkg::*;
#(
  parameter int unsigned WIN_LEN   = 256,
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned TRACK_TOL = 8,
  parameter int unsigned LOCK_TOL  = 2,
  parameter int unsigned LOCK_RUNS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pll_en,
  input  logic            ref_pulse,
  input  logic            fb_pulse,
  input  logic            vco_selected,
  input  logic            reg_wr,
  input  logic [3:0]      reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic            track_mode,
  output logic            vco_safe,
  output logic            pll_irq,
  output logic            lost_lock
);
  ctl_wr_t          wr_word;
  logic             win_done;
  logic [ERR_W-1:0] win_err;
  logic             lock, auto_track;
  logic             sw_acq, auto_en, irq_en, flag;

  assign wr_word = ctl_wr_t'(reg_wdata);

  pll_win_meter #(.WIN_LEN(WIN_LEN), .ERR_W(ERR_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .en(pll_en),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .done(win_done), .err(win_err)
  );

  pll_lock_seq #(
    .ERR_W(ERR_W), .TRACK_TOL(TRACK_TOL),
    .LOCK_TOL(LOCK_TOL), .LOCK_RUNS(LOCK_RUNS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(pll_en),
    .done(win_done), .err(win_err), .auto_en(auto_en),
    .lock(lock), .auto_track(auto_track)
  );

  pll_bw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_word(wr_word),
    .lock(lock), .sw_acq(sw_acq), .auto_en(auto_en),
    .irq_en(irq_en), .flag(flag), .irq(pll_irq)
  );

  always_comb begin
    track_mode         = auto_en ? auto_track : sw_acq;
    vco_safe           = lock;
    reg_rdata          = '0;
    reg_rdata[RD_MODE] = track_mode;
    reg_rdata[RD_AUTO] = auto_en;
    reg_rdata[RD_IE]   = irq_en;
    reg_rdata[RD_FLAG] = flag;
    reg_rdata[RD_LOCK] = lock;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lost_lock <= 1'b0;
    else        lost_lock <= vco_selected && !lock;
  end

  AST_SAFE_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_lock && $past(vco_selected)) |-> !$past(vco_safe));   // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pll_irq |-> reg_rdata[RD_FLAG]);                            // R9
endmodule

// File: tb/pll_bw_ctrl_bench.sv
`timescale 1ns/1ps
module pll_bw_ctrl_bench;
  localparam int WIN = 256;
  localparam int NV  = 12;
  // {feedback count, expected mode, expected lock}, auto mode, consecutive windows
  localparam logic [11:0] VEC [NV] = '{
    {10'd276, 1'b0, 1'b0}, {10'd261, 1'b1, 1'b0}, {10'd258, 1'b1, 1'b0},
    {10'd255, 1'b1, 1'b1}, {10'd257, 1'b1, 1'b1}, {10'd261, 1'b1, 1'b1},
    {10'd240, 1'b0, 1'b0}, {10'd256, 1'b1, 1'b0}, {10'd256, 1'b1, 1'b1},
    {10'd265, 1'b0, 1'b0}, {10'd248, 1'b1, 1'b0}, {10'd254, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, pll_en = 1'b1, ref_pulse = 1'b0, fb_pulse = 1'b0;
  logic       vco_selected = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_wdata = '0;
  logic [4:0] reg_rdata;
  logic       track_mode, vco_safe, pll_irq, lost_lock;
  int         n_chk = 0, n_bad = 0;
  bit         ended = 1'b0;

  always #2 clk = ~clk;

  pll_bw_ctrl u_pll_bw_ctrl (
    .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .ref_pulse(ref_pulse),
    .fb_pulse(fb_pulse), .vco_selected(vco_selected), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .track_mode(track_mode),
    .vco_safe(vco_safe), .pll_irq(pll_irq), .lost_lock(lost_lock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bit0 ACQ, bit1 AUTO, bit2 IE, bit3 flag clear
  task automatic wr(input logic [3:0] w);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    idle(2);
  endtask

  task automatic window(input int nfb);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk); ref_pulse = 1'b1; fb_pulse = (i < nfb);
      @(negedge clk); ref_pulse = 1'b0; fb_pulse = (i + WIN < nfb);
    end
    @(negedge clk); fb_pulse = 1'b0;
    idle(5);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    chk("R1 mode", track_mode, 0);
    chk("R1 lock", vco_safe, 0);
    chk("R1 readback", reg_rdata, 0);
    chk("R1 irq", pll_irq, 0);

    wr(4'b0110);                                  // AUTO=1, IE=1
    chk("R11 readback auto/ie", reg_rdata, 5'b00110);

    for (int v = 0; v < NV; v++) begin
      window(int'(VEC[v][11:2]));
      chk("R3 auto mode", track_mode, VEC[v][1]);
      chk("R4/R5 lock", reg_rdata[4], VEC[v][0]);
      chk("R7 safe", vco_safe, VEC[v][0]);
      chk("R2 R11 mode bit", reg_rdata[0], VEC[v][1]);
    end

    chk("R8 flag sticky", reg_rdata[3], 1);
    chk("R9 irq", pll_irq, 1);
    wr(4'b1110);                                  // clear flag
    chk("R8 flag clear", reg_rdata[3], 0);
    chk("R9 irq off", pll_irq, 0);

    wr(4'b0101);                                  // manual, ACQ=1
    chk("R6 manual track", track_mode, 1);
    window(256);
    chk("R4 manual lock", vco_safe, 1);
    chk("R6 manual keeps", track_mode, 1);
    chk("R8 flag on rise", reg_rdata[3], 1);
    chk("R9 irq on", pll_irq, 1);
    wr(4'b0100);                                  // manual, ACQ=0
    chk("R6 manual acq", track_mode, 0);
    chk("R6 lock kept", vco_safe, 1);
    window(280);
    chk("R5 manual unlock", vco_safe, 0);
    chk("R6 no auto back", track_mode, 0);
    window(256);
    chk("R6 no auto track", track_mode, 0);
    chk("R4 one good", vco_safe, 0);

    vco_selected = 1'b1;
    idle(3);
    chk("R10 lost", lost_lock, 1);
    wr(4'b1010);                                  // AUTO=1, IE=0, clear
    chk("R8 clear again", reg_rdata[3], 0);
    window(256);
    chk("R4 lock back", vco_safe, 1);
    chk("R10 recovered", lost_lock, 0);
    chk("R8 flag", reg_rdata[3], 1);
    chk("R9 ie gate", pll_irq, 0);

    @(negedge clk); pll_en = 1'b0;
    idle(3);
    chk("R12 unlock", vco_safe, 0);
    chk("R12 acquisition", track_mode, 0);
    chk("R10 lost again", lost_lock, 1);
    pll_en = 1'b1; vco_selected = 1'b0;
    idle(3);
    chk("R10 idle", lost_lock, 0);
    window(256);
    chk("R12 restart track", track_mode, 1);
    chk("R12 restart lock", vco_safe, 0);

    ended = 1'b1;
    finish_run();
  end
endmodule